// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a byte-oriented SPI master that sits behind a simple 32-bit register bus. Software queues bytes into a 16-entry transmit FIFO and collects returned bytes from a 16-entry receive FIFO. A control register holds a transfer-inhibit bit, which is set out of reset, and two self-clearing FIFO flush bits. A slave-select register drives a parameterised set of active-low chip-select lines directly. The block has a status register for FIFO levels and a sticky event register that software clears by writing ones.

Once the inhibit bit is cleared, the byte engine pops queued bytes one at a time. It shifts each byte out in SPI mode 0: SCLK idles low, the master changes data on the falling edge, both sides sample on the rising edge, and the most significant bit goes first. Each SCLK half period lasts `CLK_DIV` system clocks. Every byte sent returns exactly one received byte. That byte goes into the receive FIFO, or it is discarded with an overrun event when the FIFO is already full. Chip-select is never toggled by the engine, so software holds it across a whole burst.

Registers sit on 4-byte boundaries and are selected by `bus_addr >> 2`, so the two low address bits are ignored. The map is: word 0 control (bit 0 inhibit, bit 1 transmit flush, bit 2 receive flush); word 1 status; word 2 transmit data (write); word 3 receive data (read); word 4 slave select; word 5 events. Other words read as zero.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, control reads 1 (inhibit set), slave select reads all ones, status reads 0x5 (receive-empty bit 0 and transmit-empty bit 2 set), events read 0, SCLK is low and every chip-select is high.
- R2: Chip-select line i equals bit i of the slave-select register, so it is driven low exactly when that bit is 0, and it changes only on a write to that register.
- R3: While the inhibit bit is 1, no SCLK edge occurs and queued transmit bytes stay in the FIFO (status bit 2 remains 0).
- R4: A write to transmit data pushes its low byte and clears status bit 2. Status bit 3 (transmit full) is set once 16 bytes are queued. A write while the FIFO is full is dropped.
- R5: Each byte produces eight SCLK pulses with a half period of `CLK_DIV` clocks, MSB first in mode 0. Consecutive queued bytes are sent back to back, each yielding one received byte assembled MSB first from MISO.
- R6: With the engine idle and enabled, a received byte is in the receive FIFO (status bit 0 clears) exactly 1 + 16·`CLK_DIV` clocks after the clock edge that accepted the transmit write, and not one clock earlier.
- R7: A read of receive data pops one byte. The read after the last byte sets status bit 0. A read while empty returns 0 and pops nothing.
- R8: A byte that completes while the receive FIFO is full is discarded, and event bit 2 (overrun) is set. Status bit 1 is the receive-full flag.
- R9: Event bit 3 is set when a byte completes and the transmit FIFO is empty.
- R10: Event bit 0 is set while the receive FIFO is non-empty, and event bit 1 is set while it is full. Writing 1 to any event bit clears it unless its condition still holds.
- R11: Writing control bit 1 empties the transmit FIFO, and writing control bit 2 empties the receive FIFO. Each restores its empty flag to 1 and its full flag to 0.
- R12: The two low address bits are ignored, and reads of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a receive-data read pops on this clock edge |
| bus_addr | input | 5 | Byte address; word index is bits 4:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd`, 0 otherwise |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in, sampled as SCLK rises |
| cs_n | output | NUM_CS | Active-low chip selects, one per slave-select bit |

## Verification
Register writes, flushes, chip-select changes and status flags take effect at the clock edge that accepts the bus cycle, so they are checked on the following falling edge. Read data is combinational and is sampled before the popping edge. The one multi-cycle result, a received byte, is due 1 + 16·`CLK_DIV` edges after the transmit write. One test probes the status on the falling edge just before that edge and again just after it. The other transfer tests wait a margin past the byte time before reading the serial capture and the receive FIFO.

// File: rtl/spi_host_pkg.sv
// Shared constants for the SPI master controller: address width,
// register word indices and bit positions in control and event registers.
package spi_host_pkg;
    localparam int ADDR_W = 5;
    localparam int WORD_W = ADDR_W - 2;

    typedef enum logic [WORD_W-1:0] {
        RI_CTRL = 3'd0,
        RI_STAT = 3'd1,
        RI_TXD  = 3'd2,
        RI_RXD  = 3'd3,
        RI_SSEL = 3'd4,
        RI_EVT  = 3'd5
    } reg_idx_e;

    localparam int CTRL_INHIBIT = 0;
    localparam int CTRL_TXCLR   = 1;
    localparam int CTRL_RXCLR   = 2;

    localparam int EV_RX_NONEMPTY = 0;
    localparam int EV_RX_FULL     = 1;
    localparam int EV_RX_OVERRUN  = 2;
    localparam int EV_TX_DONE     = 3;
    localparam int NUM_EV         = 4;
endpackage

// File: rtl/byte_fifo.sv
// Synchronous FIFO with flush. Push while full and pop while empty are
// ignored. Assumes DEPTH is a power of two so pointers wrap naturally.
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write, no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping, flush returns to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full)
        else $error("fifo lost full state on dropped push");

    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty)
        else $error("fifo popped while empty");
endmodule

// File: rtl/spi_byte_engine.sv
// Mode-0 SPI byte shifter. Takes one byte when enabled and data is
// available, sends it MSB first with SCLK half period CLK_DIV clocks,
// and pulses rx_done for one cycle with the received byte.
// Assumes CLK_DIV >= 1; chip-select is managed outside.
module spi_byte_engine #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inhibit,
    input  logic       tx_avail,
    input  logic [7:0] tx_byte,
    output logic       tx_take,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic       rx_done,
    output logic [7:0] rx_byte
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_e;

    eng_state_e    state;
    logic [CW-1:0] cnt;
    logic [2:0]    bitcnt;
    logic [7:0]    tx_sh, rx_sh;
    logic          tick;

    assign tick    = (cnt == '0);
    assign tx_take = (state == ENG_IDLE) && !inhibit && tx_avail;
    assign rx_done = (state == ENG_SHIFT) && tick && sclk && (bitcnt == 3'd7);
    assign rx_byte = rx_sh;
    assign mosi    = tx_sh[7];

    // Half-period timer, SCLK toggling and the two shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            cnt    <= '0;
            sclk   <= 1'b0;
            bitcnt <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (tx_take) begin
                        tx_sh  <= tx_byte;
                        cnt    <= CW'(CLK_DIV - 1);
                        bitcnt <= '0;
                        state  <= ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    if (!tick) begin
                        cnt <= cnt - CW'(1);
                    end else begin
                        cnt <= CW'(CLK_DIV - 1);
                        if (!sclk) begin
                            sclk  <= 1'b1;
                            rx_sh <= {rx_sh[6:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (bitcnt == 3'd7) begin
                                state <= ENG_IDLE;
                            end else begin
                                bitcnt <= bitcnt + 3'd1;
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                            end
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_IDLE && inhibit) |=> (state == ENG_IDLE && !sclk))
        else $error("engine started while inhibited");

    p_idle_sclk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_IDLE) |-> !sclk)
        else $error("sclk high while idle");

    p_mosi_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi))
        else $error("mosi changed while sclk high");
endmodule

// File: rtl/spi_host_ctrl.sv
// Register-mapped SPI master: control, status, slave-select and event
// registers around a transmit FIFO, a receive FIFO and a mode-0 byte
// engine. Registers are word-indexed by bus_addr >> 2; reads are
// combinational and a receive-data read pops on the same clock edge.
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int NUM_CS     = 1,
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_DIV    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    logic [WORD_W-1:0] word;
    logic              wr_ctrl, wr_txd, wr_ssel, wr_evt, rd_rxd;
    logic              inhibit;
    logic [NUM_CS-1:0] ssel;
    logic [NUM_EV-1:0] evt, evt_set;
    logic              tx_empty, tx_full, tx_take;
    logic              rx_empty, rx_full, rx_done;
    logic [7:0]        tx_head, rx_head, rx_byte;
    logic [3:0]        status;
    logic              unused_ok;

    assign unused_ok = ^{bus_wdata[31:8], bus_addr[1:0]};

    assign word    = bus_addr[ADDR_W-1:2];
    assign wr_ctrl = bus_wr && (word == RI_CTRL);
    assign wr_txd  = bus_wr && (word == RI_TXD);
    assign wr_ssel = bus_wr && (word == RI_SSEL);
    assign wr_evt  = bus_wr && (word == RI_EVT);
    assign rd_rxd  = bus_rd && (word == RI_RXD);

    assign cs_n   = ssel;
    assign status = {tx_full, tx_empty, rx_full, rx_empty};

    byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .clr(wr_ctrl && bus_wdata[CTRL_TXCLR]),
        .push(wr_txd), .pop(tx_take), .din(bus_wdata[7:0]),
        .dout(tx_head), .empty(tx_empty), .full(tx_full)
    );

    byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .clr(wr_ctrl && bus_wdata[CTRL_RXCLR]),
        .push(rx_done), .pop(rd_rxd), .din(rx_byte),
        .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .inhibit(inhibit),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_take(tx_take),
        .sclk(sclk), .mosi(mosi), .miso(miso),
        .rx_done(rx_done), .rx_byte(rx_byte)
    );

    // Event sources for this cycle.
    always_comb begin
        evt_set                 = '0;
        evt_set[EV_RX_NONEMPTY] = !rx_empty;
        evt_set[EV_RX_FULL]     = rx_full;
        evt_set[EV_RX_OVERRUN]  = rx_done && rx_full;
        evt_set[EV_TX_DONE]     = rx_done && tx_empty;
    end

    // Control, slave-select and sticky event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit <= 1'b1;
            ssel    <= '1;
            evt     <= '0;
        end else begin
            if (wr_ctrl) inhibit <= bus_wdata[CTRL_INHIBIT];
            if (wr_ssel) ssel <= bus_wdata[NUM_CS-1:0];
            evt <= (evt & ~(wr_evt ? bus_wdata[NUM_EV-1:0] : '0)) | evt_set;
        end
    end

    // Combinational read mux; zero when no read is in progress.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (word)
                RI_CTRL: bus_rdata = 32'(inhibit);
                RI_STAT: bus_rdata = 32'(status);
                RI_RXD:  bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
                RI_SSEL: bus_rdata = 32'(ssel);
                RI_EVT:  bus_rdata = 32'(evt);
                default: bus_rdata = '0;
            endcase
        end
    end

    p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(cs_n))
        else $error("chip select moved without a write");

    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full) |=> (evt[EV_RX_OVERRUN] && rx_full))
        else $error("overrun not flagged");

    p_txdone_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && tx_empty) |=> evt[EV_TX_DONE])
        else $error("transmit-done event missing");
endmodule

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int NCS        = 2;
    localparam int BYTE_CYC   = 1 + 16 * DIV;

    localparam logic [4:0] A_CTRL = 5'd0,  A_STAT = 5'd4,  A_TXD = 5'd8;
    localparam logic [4:0] A_RXD  = 5'd12, A_SSEL = 5'd16, A_EVT = 5'd20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           sclk, mosi, miso;
    logic [NCS-1:0] cs_n;

    int n_chk = 0, n_fail = 0;
    logic [7:0] slave_byte = 8'h00;
    logic [2:0] bit_idx = '0;
    logic [7:0] mosi_cap = '0;
    int         rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_host_ctrl #(.NUM_CS(NCS), .FIFO_DEPTH(16), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // Slave model: drives slave_byte MSB first, records MOSI on rising SCLK.
    assign miso = slave_byte[~bit_idx];
    always @(posedge sclk) begin
        mosi_cap <= {mosi_cap[6:0], mosi};
        bit_idx  <= bit_idx + 3'd1;
        rises    <= rises + 1;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Side-effect-free look between edges (not used on the receive register).
    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_CTRL, d); chk("R1 ctrl", d, 32'h1);
        bus_read(A_SSEL, d); chk("R1 ssel", d, 32'h3);
        bus_read(A_STAT, d); chk("R1 status", d, 32'h5);
        bus_read(A_EVT, d);  chk("R1 events", d, 32'h0);
        chk("R1 cs_n", 32'(cs_n), 32'h3);
        chk("R1 sclk", 32'(sclk), 32'h0);
    endtask

    task automatic t_chip_select();
        bus_write(A_SSEL, 32'h2); chk("R2 cs_n 10", 32'(cs_n), 32'h2);
        bus_write(A_SSEL, 32'h1); chk("R2 cs_n 01", 32'(cs_n), 32'h1);
        bus_write(A_SSEL, 32'h3); chk("R2 cs_n 11", 32'(cs_n), 32'h3);
    endtask

    task automatic t_inhibit_and_txflush();
        logic [31:0] d;
        int r0 = rises;
        bus_write(A_TXD, 32'hA5);
        repeat (3 * BYTE_CYC) @(negedge clk);
        chk("R3 no sclk edges", 32'(rises - r0), 32'h0);
        bus_read(A_STAT, d); chk("R3 tx kept queued", d, 32'h1);
        bus_write(A_CTRL, 32'h3);
        bus_read(A_STAT, d); chk("R11 tx flush", d, 32'h5);
    endtask

    task automatic t_addressing();
        logic [31:0] d;
        bus_write(A_SSEL + 5'd3, 32'h2);
        chk("R12 low bits ignored", 32'(cs_n), 32'h2);
        bus_read(5'd28, d); chk("R12 unmapped read", d, 32'h0);
        bus_write(A_SSEL, 32'h3);
    endtask

    task automatic t_single_byte();
        logic [31:0] d;
        int r0;
        bus_write(A_CTRL, 32'h0);
        slave_byte = 8'h3C;
        r0 = rises;
        bus_write(A_TXD, 32'h1A5);
        repeat (BYTE_CYC - 1) @(negedge clk);
        peek(A_STAT, d); chk("R6 not yet received", d[0], 1'b1);
        @(negedge clk);
        peek(A_STAT, d); chk("R6 received on time", d[0], 1'b0);
        repeat (4) @(negedge clk);
        chk("R5 mosi MSB first", 32'(mosi_cap), 32'hA5);
        chk("R5 eight sclk pulses", 32'(rises - r0), 32'd8);
        bus_read(A_EVT, d); chk("R9 R10 events", d, 32'h9);
        bus_read(A_RXD, d); chk("R5 rx byte", d, 32'h3C);
        bus_read(A_STAT, d); chk("R7 rx empty after pop", d, 32'h5);
        bus_read(A_RXD, d); chk("R7 empty read zero", d, 32'h0);
        bus_write(A_EVT, 32'hF);
        bus_read(A_EVT, d); chk("R10 w1c clears", d, 32'h0);
    endtask

    task automatic t_burst();
        logic [31:0] d;
        int r0 = rises;
        slave_byte = 8'h5A;
        bus_write(A_TXD, 32'h11);
        bus_write(A_TXD, 32'h22);
        bus_write(A_TXD, 32'h33);
        repeat (3 * BYTE_CYC + 6) @(negedge clk);
        chk("R5 burst mosi last", 32'(mosi_cap), 32'h33);
        chk("R5 burst pulses", 32'(rises - r0), 32'd24);
        for (int i = 0; i < 3; i++) begin
            bus_read(A_RXD, d); chk("R5 burst rx", d, 32'h5A);
        end
        bus_read(A_STAT, d); chk("R7 drained", d, 32'h5);
        bus_write(A_EVT, 32'hF);
    endtask

    task automatic t_full_overrun();
        logic [31:0] d;
        int r0;
        bus_write(A_CTRL, 32'h1);
        for (int i = 0; i < 16; i++) bus_write(A_TXD, 32'h40 + i);
        bus_read(A_STAT, d); chk("R4 tx full", d, 32'h9);
        bus_write(A_TXD, 32'hEE);
        r0 = rises;
        slave_byte = 8'h11;
        bus_write(A_CTRL, 32'h0);
        repeat (16 * BYTE_CYC + 10) @(negedge clk);
        chk("R4 dropped write not sent", 32'(rises - r0), 32'd128);
        chk("R4 last sent byte", 32'(mosi_cap), 32'h4F);
        bus_read(A_STAT, d); chk("R8 rx full status", d, 32'h6);
        bus_read(A_EVT, d);  chk("R10 full event no overrun", d, 32'hB);
        slave_byte = 8'h22;
        bus_write(A_TXD, 32'h77);
        repeat (BYTE_CYC + 6) @(negedge clk);
        bus_read(A_EVT, d); chk("R8 overrun event", d[2], 1'b1);
        for (int i = 0; i < 16; i++) begin
            bus_read(A_RXD, d); chk("R8 kept bytes", d, 32'h11);
        end
        bus_read(A_RXD, d); chk("R8 overrun byte dropped", d, 32'h0);
        bus_write(A_EVT, 32'hF);
    endtask

    task automatic t_rx_flush();
        logic [31:0] d;
        slave_byte = 8'h99;
        bus_write(A_TXD, 32'h01);
        repeat (BYTE_CYC + 4) @(negedge clk);
        bus_read(A_STAT, d); chk("R11 rx has data", d[0], 1'b0);
        bus_write(A_CTRL, 32'h4);
        bus_read(A_STAT, d); chk("R11 rx flush", d, 32'h5);
        bus_read(A_RXD, d);  chk("R11 flushed read zero", d, 32'h0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chip_select();
        t_inhibit_and_txflush();
        t_addressing();
        t_single_byte();
        t_burst();
        t_full_overrun();
        t_rx_flush();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule